// File: doc/BRIEF.md
# Priority Link Frame Multiplexer

This block lets several message classes share a single serial link. Each class delivers words through its own valid/ready queue, with a last flag marking the final word of a message. The multiplexer cuts messages into frames of at most `MAX_FRAME` words and emits one tagged word per accepted cycle toward an external serializer. A frame is never interleaved with another class. Between frames, the lowest-numbered class that has data wins. A time-critical class therefore waits at most for the rest of the frame already on the wire. It never waits for the rest of a long bulk message.

Toward the trigger the block is built with four classes. In priority order these are time-marked track stubs (tag 0), critical status (tag 1), raw readout data (tag 2) and slow control (tag 3). Toward the front end the same module is built with `NCLS = 2`: tag 0 carries accept decisions with their time marker and tag 1 carries slow-control traffic.

The output is a stream that is always valid after reset. When there is no data word to send, the block presents an idle word, flagged by `out_idle` and carrying `IDLE_WORD`.

The back-pressure rules are as follows:
- While `out_ready` is low, no input queue is accepted.
- A data word that has been presented and not yet accepted keeps the same class. Its source must hold it, as valid/ready requires.
- An idle word may be replaced by data at any time.

Top module: `plfm_link_mux`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `out_valid` and every `in_ready` bit are 0. Once the block is running with nothing to send, it presents an idle word: `out_valid`=1, `out_idle`=1, `out_data`=`IDLE_WORD` (default 16'hBC5A), `out_tag`=0, and both frame flags 0.
- R2: At a frame boundary (no frame open), the valid class with the lowest index is granted. Class 0 has the highest priority.
- R3: Every data word carries its class index on the 2-bit `out_tag`, and the data of class c appears unchanged on `out_data`.
- R4: A frame closes on the word that completes `MAX_FRAME` (default 4) accepted words, or on the word whose last flag is set, whichever comes first. `out_frame_end` is 1 on exactly that word.
- R5: `out_msg_end` is 1 only on a data word whose input last flag is set. Such a word always also has `out_frame_end`=1.
- R6: While a frame is open, no other class is accepted, even one of higher priority. The higher-priority class is granted on the first word after the frame closes.
- R7: If the class owning an open frame has no valid word, an idle word is sent, no `in_ready` is raised, and the frame stays owned by that class.
- R8: With `out_ready` low, all `in_ready` bits are 0. A presented data word keeps its class, tag and data until it is accepted, even if a higher-priority class becomes valid meanwhile.
- R9: At most one `in_ready` bit is high. It is the granted class, and only when that class is valid and `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NCLS | Per-class word valid |
| in_ready | output | NCLS | Per-class word accepted |
| in_data | input | NCLS*DATA_W | Per-class word, class c in bits c*DATA_W upward |
| in_last | input | NCLS | Per-class last word of message |
| out_valid | output | 1 | Output word valid (data or idle) |
| out_ready | input | 1 | Serializer takes the word |
| out_data | output | DATA_W | Data word or idle pattern |
| out_tag | output | 2 | Class of the data word |
| out_idle | output | 1 | Word is an idle filler |
| out_frame_end | output | 1 | Final word of the current frame |
| out_msg_end | output | 1 | Final word of the message (last frame) |

## Verification
Two events can fall on the same word. The first is the close forced by the frame-length limit coinciding with a message end. The bench drives a four-word message and expects both flags together, and it also drives a five-word message, where it expects the length close without the message flag and then a one-word frame. The second pair is a stall on a boundary word coinciding with the arrival of a higher-priority class. This is provoked by holding `out_ready` low while class 0 rises behind a presented class 1 or class 2 word. The bench judges it by the tag and data staying put until acceptance, with the higher class served only afterwards.

// File: rtl/plfm_pkg.sv
package plfm_pkg;
  localparam int TAG_W       = 2;
  localparam int MAX_CLASSES = 1 << TAG_W;
  typedef logic [TAG_W-1:0] tag_t;
endpackage

// File: rtl/plfm_prio_pick.sv
// Lowest index among the requesting classes wins.
module plfm_prio_pick
  import plfm_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output tag_t         idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = tag_t'(i);
    end
  end
endmodule

// File: rtl/plfm_frame_ctl.sv
// Frame ownership, word count within the frame, and stall hold.
module plfm_frame_ctl
  import plfm_pkg::*;
#(
  parameter int MAX_FRAME = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic acc,
  input  logic stall,
  input  tag_t cur_cls,
  input  logic cur_last,
  output logic locked,
  output tag_t lock_cls,
  output logic hold_active,
  output tag_t hold_cls,
  output logic closes
);
  localparam int CNT_W = $clog2(MAX_FRAME + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_FRAME - 1);

  typedef struct packed {
    logic             locked;
    tag_t             cls;
    logic [CNT_W-1:0] cnt;
  } frame_st_t;

  frame_st_t st_q, st_d;

  // cnt is zero whenever no frame is open
  assign closes = cur_last || (st_q.cnt == LAST_IDX);

  always_comb begin
    st_d = st_q;
    if (acc) begin
      if (closes) begin
        st_d = '0;
      end else begin
        st_d.locked = 1'b1;
        st_d.cls    = cur_cls;
        st_d.cnt    = st_q.cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= '0;
      hold_active <= 1'b0;
      hold_cls    <= '0;
    end else begin
      st_q        <= st_d;
      hold_active <= stall;
      hold_cls    <= cur_cls;
    end
  end

  assign locked   = st_q.locked;
  assign lock_cls = st_q.cls;
endmodule

// File: rtl/plfm_link_mux.sv
module plfm_link_mux
  import plfm_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter int                NCLS      = 4,
  parameter int                MAX_FRAME = 4,
  parameter logic [DATA_W-1:0] IDLE_WORD = DATA_W'('hBC5A)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCLS-1:0]        in_valid,
  output logic [NCLS-1:0]        in_ready,
  input  logic [NCLS*DATA_W-1:0] in_data,
  input  logic [NCLS-1:0]        in_last,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [DATA_W-1:0]      out_data,
  output logic [TAG_W-1:0]       out_tag,
  output logic                   out_idle,
  output logic                   out_frame_end,
  output logic                   out_msg_end
);
  logic              running;
  tag_t              pick_idx, grant, lock_cls, hold_cls;
  logic              locked, hold_active, closes;
  logic [NCLS-1:0]   sel_oh;
  logic [DATA_W-1:0] sel_data;
  logic              sel_last, sel_valid, present;

  always_ff @(posedge clk) begin
    if (rst) running <= 1'b0;
    else     running <= 1'b1;
  end

  plfm_prio_pick #(.N(NCLS)) u_pick (
    .req (in_valid),
    .idx (pick_idx)
  );

  // Open frame first, then a stalled word, then fresh priority.
  always_comb begin
    if (locked)           grant = lock_cls;
    else if (hold_active) grant = hold_cls;
    else                  grant = pick_idx;
  end

  generate
    for (genvar c = 0; c < NCLS; c++) begin : g_dec
      assign sel_oh[c] = (grant == tag_t'(c));
    end
  endgenerate

  always_comb begin
    sel_data  = '0;
    sel_last  = 1'b0;
    sel_valid = 1'b0;
    for (int c = 0; c < NCLS; c++) begin
      if (sel_oh[c]) begin
        sel_data  = in_data[c*DATA_W +: DATA_W];
        sel_last  = in_last[c];
        sel_valid = in_valid[c];
      end
    end
  end

  assign present = running && sel_valid;

  plfm_frame_ctl #(.MAX_FRAME(MAX_FRAME)) u_frame (
    .clk         (clk),
    .rst         (rst),
    .acc         (present && out_ready),
    .stall       (present && !out_ready),
    .cur_cls     (grant),
    .cur_last    (sel_last),
    .locked      (locked),
    .lock_cls    (lock_cls),
    .hold_active (hold_active),
    .hold_cls    (hold_cls),
    .closes      (closes)
  );

  assign out_valid     = running;
  assign out_idle      = !present;
  assign out_data      = present ? sel_data : IDLE_WORD;
  assign out_tag       = present ? grant : '0;
  assign out_frame_end = present && closes;
  assign out_msg_end   = present && sel_last;
  assign in_ready      = (present && out_ready) ? sel_oh : '0;
endmodule

// File: rtl/plfm_link_mux_chk.sv
module plfm_link_mux_chk #(
  parameter int NCLS      = 4,
  parameter int MAX_FRAME = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [NCLS-1:0] in_valid,
  input logic [NCLS-1:0] in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [1:0]      out_tag,
  input logic            out_idle,
  input logic            out_frame_end,
  input logic            out_msg_end
);
  localparam int CNT_W = $clog2(MAX_FRAME + 1);

  logic             acc_w;
  logic [CNT_W-1:0] seen;

  assign acc_w = out_valid && out_ready && !out_idle;

  always_ff @(posedge clk) begin
    if (rst)                         seen <= '0;
    else if (acc_w && out_frame_end) seen <= '0;
    else if (acc_w)                  seen <= seen + 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready == '0));

  a_r3_tag_range: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_idle) |-> (int'(out_tag) < NCLS));

  a_r4_frame_len: assert property (@(posedge clk) disable iff (rst)
    (acc_w && !out_frame_end) |-> (seen < CNT_W'(MAX_FRAME - 1)));

  a_r5_msg_closes_frame: assert property (@(posedge clk) disable iff (rst)
    out_msg_end |-> out_frame_end);

  a_r6_stay_in_class: assert property (@(posedge clk) disable iff (rst)
    (acc_w && !out_frame_end) |=> (out_idle || out_tag == $past(out_tag)));

  a_r7_idle_no_ready: assert property (@(posedge clk) disable iff (rst)
    out_idle |-> (in_ready == '0));

  a_r8_stall_no_ready: assert property (@(posedge clk) disable iff (rst)
    !out_ready |-> (in_ready == '0));

  a_r8_hold_word: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_idle && !out_ready) |=> (!out_idle && $stable(out_tag)));

  a_r9_ready_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_ready));

  a_r9_ready_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (in_ready & ~in_valid) == '0);
endmodule

bind plfm_link_mux plfm_link_mux_chk #(.NCLS(NCLS), .MAX_FRAME(MAX_FRAME)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_tag       (out_tag),
  .out_idle      (out_idle),
  .out_frame_end (out_frame_end),
  .out_msg_end   (out_msg_end)
);

// File: tb/plfm_link_mux_tb_top.sv
module plfm_link_mux_tb_top;
  localparam int DW = 16;
  localparam int NC = 4;
  localparam logic [DW-1:0] IDLE = 16'hBC5A;
  localparam int NVEC = 25;

  // {valid[3:0], last[3:0], out_ready, exp_idle, exp_tag[1:0], exp_fe, exp_me, exp_ready[3:0]}
  localparam logic [17:0] TBL [NVEC] = '{
    {4'b0000, 4'b0000, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 4'b0000},
    {4'b1000, 4'b0000, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 4'b1000},
    {4'b1001, 4'b0000, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 4'b1000},
    {4'b1001, 4'b0000, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 4'b1000},
    {4'b1001, 4'b0000, 1'b1, 1'b0, 2'd3, 1'b1, 1'b0, 4'b1000},
    {4'b1001, 4'b0001, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 4'b0001},
    {4'b1100, 4'b0100, 1'b1, 1'b0, 2'd2, 1'b1, 1'b1, 4'b0100},
    {4'b1000, 4'b0000, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 4'b1000},
    {4'b0000, 4'b0000, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 4'b0000},
    {4'b0011, 4'b0000, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 4'b0000},
    {4'b1011, 4'b1000, 1'b1, 1'b0, 2'd3, 1'b1, 1'b1, 4'b1000},
    {4'b0010, 4'b0000, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 4'b0000},
    {4'b0011, 4'b0000, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 4'b0000},
    {4'b0011, 4'b0010, 1'b1, 1'b0, 2'd1, 1'b1, 1'b1, 4'b0010},
    {4'b0001, 4'b0001, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 4'b0001},
    {4'b0100, 4'b0000, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 4'b0100},
    {4'b0100, 4'b0000, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 4'b0100},
    {4'b0100, 4'b0000, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 4'b0100},
    {4'b0100, 4'b0000, 1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 4'b0100},
    {4'b0100, 4'b0100, 1'b1, 1'b0, 2'd2, 1'b1, 1'b1, 4'b0100},
    {4'b0010, 4'b0000, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 4'b0010},
    {4'b0010, 4'b0000, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 4'b0010},
    {4'b0010, 4'b0000, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 4'b0010},
    {4'b0010, 4'b0010, 1'b1, 1'b0, 2'd1, 1'b1, 1'b1, 4'b0010},
    {4'b0000, 4'b0000, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 4'b0000}
  };

  logic             clk = 1'b0;
  logic             rst;
  logic [NC-1:0]    in_valid, in_ready, in_last;
  logic [NC*DW-1:0] in_data;
  logic             out_valid, out_ready, out_idle, out_frame_end, out_msg_end;
  logic [DW-1:0]    out_data;
  logic [1:0]       out_tag;
  int               n_chk = 0;
  int               n_bad = 0;
  bit               done  = 1'b0;

  always #2 clk = ~clk;

  plfm_link_mux dut_i (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_data       (in_data),
    .in_last       (in_last),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .out_tag       (out_tag),
    .out_idle      (out_idle),
    .out_frame_end (out_frame_end),
    .out_msg_end   (out_msg_end)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] v, logic [3:0] l, logic r, int k);
    in_valid  = v;
    in_last   = l;
    out_ready = r;
    for (int c = 0; c < NC; c++) in_data[c*DW +: DW] = {2'(c), 2'b00, 12'(k)};
  endtask

  function automatic string tbl_req(int k);
    if (k == 0 || k == 24)  return "R1";
    if (k == 1)             return "R3";
    if (k <= 3)             return "R6";
    if (k == 4)             return "R4";
    if (k <= 6)             return "R2";
    if (k <= 10)            return "R7";
    if (k <= 13)            return "R8";
    if (k == 14)            return "R9";
    if (k <= 19)            return "R4";
    return "R5";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive(4'b0000, 4'b0000, 1'b1, 0);
    repeat (3) @(negedge clk);
    // R1: queues offering data during reset are not accepted
    drive(4'b1111, 4'b0000, 1'b1, 0);
    @(negedge clk);
    #1;
    check("R1", "out_valid in reset", 32'(out_valid), 32'd0);
    check("R1", "in_ready in reset", 32'(in_ready), 32'd0);
    drive(4'b0000, 4'b0000, 1'b1, 0);
    rst = 1'b0;

    for (int k = 0; k < NVEC; k++) begin
      logic [17:0] e;
      logic [DW-1:0] exp_d;
      e = TBL[k];
      @(negedge clk);
      drive(e[17:14], e[13:10], e[9], k);
      #1;
      exp_d = e[8] ? IDLE : {e[7:6], 2'b00, 12'(k)};
      check(tbl_req(k), $sformatf("vector %0d", k),
            {6'd0, out_valid, out_idle, out_tag, out_frame_end, out_msg_end, in_ready, out_data},
            {6'd0, 1'b1, e[8], e[7:6], e[5], e[4], e[3:0], exp_d});
    end

    // R8: stalled class-2 word holds while class 0 shows up
    @(negedge clk);
    drive(4'b0100, 4'b0000, 1'b0, 0);
    in_data[2*DW +: DW] = 16'h1234;
    #1;
    check("R8", "tag before stall", 32'(out_tag), 32'd2);
    @(negedge clk);
    in_valid = 4'b0101;
    in_last  = 4'b0001;
    in_data[0 +: DW] = 16'h0ABC;
    #1;
    check("R8", "held data", 32'(out_data), 32'h1234);
    check("R8", "held tag", 32'(out_tag), 32'd2);
    check("R8", "no ready while stalled", 32'(in_ready), 32'd0);
    @(negedge clk);
    out_ready = 1'b1;
    in_last   = 4'b0101;
    #1;
    check("R9", "ready to held class", 32'(in_ready), 32'b0100);
    check("R5", "message end flag", 32'(out_msg_end), 32'd1);
    @(negedge clk);
    in_valid = 4'b0001;
    in_last  = 4'b0001;
    #1;
    check("R2", "class 0 next", 32'(out_tag), 32'd0);
    check("R3", "class 0 data", 32'(out_data), 32'h0ABC);
    @(negedge clk);
    in_valid = 4'b0000;
    in_last  = 4'b0000;
    #1;
    check("R1", "idle pattern", 32'(out_data), 32'(IDLE));
    check("R1", "idle flag", 32'(out_idle), 32'd1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule